// File: doc/BRIEF.md
# Segmented Gamma Palette Loader

This block is the register-write front end that fills a three-segment gamma table. Software programs an index register and then streams 32-bit words into a data register. Each table point needs two data words. The word at an even index holds the 6 least significant bits of red, green and blue. The word at the following odd index holds the 10 most significant bits of the same three channels. The block joins the two halves into three 16-bit channel values. It then issues one table write carrying a segment code and a point number.

There are two independent index/data pairs. One serves the 9-point superfine segment. The other is shared by the fine segment (points 1 to 255) and the coarse segment (points 0 to 255). On the shared pair, word index divided by two gives an entry number. Entries 0 to 254 land on fine points 1 to 255, and entries 255 to 510 land on coarse points 0 to 255. The index can advance by itself after each data word. Writes beyond the last entry of a pair are dropped, and this raises a sticky flag for that pair.

Top module: `gamma_pal_wport`

## Requirements
- R1: After reset, `lut_we` is low and both overflow flags are low.
- R2: Register addresses are decoded as follows: 0 is the superfine index, 1 is the superfine data, 2 is the shared index and 3 is the shared data. The two pairs keep fully separate state.
- R3: An index write loads the word index from data bits 9:0 and the auto-advance enable from bit 15. With the enable set, every accepted data write adds one to that pair's word index.
- R4: With the enable clear, the word index stays fixed across data writes. Repeated words fall into the same half slot and never walk past the end of the table.
- R5: An even word index takes the low halves: red from bits 29:24, green from bits 19:14 and blue from bits 5:0. An odd word index takes the high halves: red from bits 29:20, green from bits 19:10 and blue from bits 9:0. Each channel is {high 10 bits, low 6 bits}.
- R6: A table write happens only on an odd-index data write whose entry already holds a low half. It appears on the outputs in the cycle after the data write, with `lut_we` high for exactly one cycle.
- R7: Any index write throws away a held low half. A high half that arrives after an index write, with no new low half, produces no table write.
- R8: On the superfine pair, entry e (0 to 8) goes out as segment code 0 and point e.
- R9: On the shared pair, entry e below 255 goes out as segment code 1 (fine) and point e+1. Entries 255 to 510 go out as segment code 2 (coarse) and point e-255.
- R10: A data write at a word index at or past the end of its pair (18 words for superfine, 1022 for shared) is dropped. It does not advance the index, and it sets that pair's overflow flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| lut_we | output | 1 | Table write strobe |
| lut_seg | output | 2 | Segment code: 0 superfine, 1 fine, 2 coarse |
| lut_point | output | 9 | Point number within the segment |
| lut_red | output | 16 | Assembled red value |
| lut_grn | output | 16 | Assembled green value |
| lut_blu | output | 16 | Assembled blue value |
| ovf_sf | output | 1 | Sticky overflow flag, superfine pair |
| ovf_sh | output | 1 | Sticky overflow flag, shared pair |

## Verification
Every table write is due exactly one clock after the edge that captures its odd data word. Each overflow flag is due after that same single edge. The driver applies each register write at a falling edge and pushes the expected table entry before it sends the high half. The monitor compares at the next falling edge, which is the first point where the registered result is stable. A table write that was not expected, or an expected one that never arrives, therefore shows up as an extra pop on an empty queue or as a non-empty queue at the end. Flag checks and "no write" checks are made at the same one-cycle offset after the stimulus that could have caused them.

// File: rtl/gpal_pkg.sv
package gpal_pkg;

   typedef enum logic [1:0] {
      SEG_SUPER  = 2'd0,
      SEG_FINE   = 2'd1,
      SEG_COARSE = 2'd2
   } seg_e;

   // register select codes
   localparam logic [1:0] A_SF_IDX = 2'd0;
   localparam logic [1:0] A_SF_DAT = 2'd1;
   localparam logic [1:0] A_SH_IDX = 2'd2;
   localparam logic [1:0] A_SH_DAT = 2'd3;

   // channel split
   localparam int CH_W    = 16;
   localparam int LO_W    = 6;
   localparam int HI_W    = CH_W - LO_W;

   // low-half word field positions
   localparam int R_LO_AT = 24;
   localparam int G_LO_AT = 14;
   localparam int B_LO_AT = 0;
   // high-half word field positions
   localparam int R_HI_AT = 20;
   localparam int G_HI_AT = 10;
   localparam int B_HI_AT = 0;

   typedef struct packed {
      logic [CH_W-1:0] r;
      logic [CH_W-1:0] g;
      logic [CH_W-1:0] b;
   } rgb_t;

endpackage

// File: rtl/gpal_port.sv
module gpal_port
   import gpal_pkg::*;
#(
   parameter int DW     = 32,
   parameter int IDX_W  = 10,
   parameter int AI_BIT = 15,
   parameter int N_ENT  = 9,
   localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_wr,
   input  logic             dat_wr,
   input  logic [DW-1:0]    wdata,
   output logic             ent_we,
   output logic [ENT_W-1:0] ent_num,
   output rgb_t             ent_rgb,
   output logic             ovf
);

   localparam int WORDS = 2 * N_ENT;

   if (WORDS > (1 << IDX_W)) begin : g_bad_idx
      $error("gpal_port: IDX_W too narrow for N_ENT");
   end
   if (AI_BIT < IDX_W || AI_BIT >= DW) begin : g_bad_ai
      $error("gpal_port: AI_BIT overlaps index field or exceeds DW");
   end
   if (R_LO_AT + LO_W > DW || R_HI_AT + HI_W > DW) begin : g_bad_fld
      $error("gpal_port: channel fields exceed data width");
   end

   logic [IDX_W-1:0] idx_q;
   logic             ai_q;
   logic             lo_vld_q;
   logic [IDX_W-2:0] lo_ent_q;
   logic [LO_W-1:0]  lo_r_q, lo_g_q, lo_b_q;
   logic             we_q;
   logic [ENT_W-1:0] num_q;
   rgb_t             rgb_q;
   logic             ovf_q;

   logic             in_range;
   logic [IDX_W-2:0] cur_ent;
   logic             pair_ok;

   always_comb begin
      in_range = ({1'b0, idx_q} < (IDX_W+1)'(WORDS));
      cur_ent  = idx_q[IDX_W-1:1];
      pair_ok  = lo_vld_q && (lo_ent_q == cur_ent);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         ai_q     <= 1'b0;
         lo_vld_q <= 1'b0;
         lo_ent_q <= '0;
         lo_r_q   <= '0;
         lo_g_q   <= '0;
         lo_b_q   <= '0;
         we_q     <= 1'b0;
         num_q    <= '0;
         rgb_q    <= '0;
         ovf_q    <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (idx_wr) begin
            idx_q    <= wdata[IDX_W-1:0];
            ai_q     <= wdata[AI_BIT];
            lo_vld_q <= 1'b0;
         end else if (dat_wr) begin
            if (!in_range) begin
               ovf_q <= 1'b1;
            end else begin
               if (ai_q) begin
                  idx_q <= idx_q + 1'b1;
               end
               if (!idx_q[0]) begin
                  lo_r_q   <= wdata[R_LO_AT +: LO_W];
                  lo_g_q   <= wdata[G_LO_AT +: LO_W];
                  lo_b_q   <= wdata[B_LO_AT +: LO_W];
                  lo_vld_q <= 1'b1;
                  lo_ent_q <= cur_ent;
               end else if (pair_ok) begin
                  we_q    <= 1'b1;
                  num_q   <= ENT_W'(cur_ent);
                  rgb_q.r <= {wdata[R_HI_AT +: HI_W], lo_r_q};
                  rgb_q.g <= {wdata[G_HI_AT +: HI_W], lo_g_q};
                  rgb_q.b <= {wdata[B_HI_AT +: HI_W], lo_b_q};
               end
            end
         end
      end
   end

   assign ent_we  = we_q;
   assign ent_num = num_q;
   assign ent_rgb = rgb_q;
   assign ovf     = ovf_q;

endmodule

// File: rtl/gpal_map.sv
module gpal_map
   import gpal_pkg::*;
#(
   parameter bit SHARED    = 1'b0,
   parameter int ENT_W     = 9,
   parameter int PT_W      = 9,
   parameter int N_FINE    = 255,
   parameter int FINE_BASE = 1
) (
   input  logic [ENT_W-1:0] ent,
   output seg_e             seg,
   output logic [PT_W-1:0]  pt
);

   if (SHARED) begin : g_shared
      if (N_FINE >= (1 << ENT_W)) begin : g_bad_fine
         $error("gpal_map: N_FINE does not fit entry width");
      end
      always_comb begin
         if ({1'b0, ent} < (ENT_W+1)'(N_FINE)) begin
            seg = SEG_FINE;
            pt  = PT_W'(ent) + PT_W'(FINE_BASE);
         end else begin
            seg = SEG_COARSE;
            pt  = PT_W'(ent - ENT_W'(N_FINE));
         end
      end
   end else begin : g_super
      always_comb begin
         seg = SEG_SUPER;
         pt  = PT_W'(ent);
      end
   end

endmodule

// File: rtl/gamma_pal_wport.sv
module gamma_pal_wport
   import gpal_pkg::*;
#(
   parameter int DW        = 32,
   parameter int IDX_W     = 10,
   parameter int AI_BIT    = 15,
   parameter int N_SUPER   = 9,
   parameter int N_FINE    = 255,
   parameter int N_COARSE  = 256,
   parameter int FINE_BASE = 1,
   parameter int PT_W      = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [1:0]      reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic            lut_we,
   output logic [1:0]      lut_seg,
   output logic [PT_W-1:0] lut_point,
   output logic [15:0]     lut_red,
   output logic [15:0]     lut_grn,
   output logic [15:0]     lut_blu,
   output logic            ovf_sf,
   output logic            ovf_sh
);

   localparam int N_SH  = N_FINE + N_COARSE;
   localparam int SF_EW = (N_SUPER > 1) ? $clog2(N_SUPER) : 1;
   localparam int SH_EW = (N_SH > 1) ? $clog2(N_SH) : 1;

   if (CH_W != 16) begin : g_bad_ch
      $error("gamma_pal_wport: channel width must be 16");
   end
   if ((1 << PT_W) < N_COARSE || (1 << PT_W) <= N_FINE + FINE_BASE - 1 || (1 << PT_W) < N_SUPER) begin : g_bad_pt
      $error("gamma_pal_wport: PT_W too narrow");
   end

   logic sf_idx_wr, sf_dat_wr, sh_idx_wr, sh_dat_wr;

   always_comb begin
      sf_idx_wr = reg_wr && (reg_addr == A_SF_IDX);
      sf_dat_wr = reg_wr && (reg_addr == A_SF_DAT);
      sh_idx_wr = reg_wr && (reg_addr == A_SH_IDX);
      sh_dat_wr = reg_wr && (reg_addr == A_SH_DAT);
   end

   logic             sf_we, sh_we;
   logic [SF_EW-1:0] sf_num;
   logic [SH_EW-1:0] sh_num;
   rgb_t             sf_rgb, sh_rgb;
   seg_e             sf_seg, sh_seg;
   logic [PT_W-1:0]  sf_pt, sh_pt;

   gpal_port #(
      .DW(DW), .IDX_W(IDX_W), .AI_BIT(AI_BIT), .N_ENT(N_SUPER)
   ) u_sf_port (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(sf_idx_wr), .dat_wr(sf_dat_wr), .wdata(reg_wdata),
      .ent_we(sf_we), .ent_num(sf_num), .ent_rgb(sf_rgb), .ovf(ovf_sf)
   );

   gpal_port #(
      .DW(DW), .IDX_W(IDX_W), .AI_BIT(AI_BIT), .N_ENT(N_SH)
   ) u_sh_port (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(sh_idx_wr), .dat_wr(sh_dat_wr), .wdata(reg_wdata),
      .ent_we(sh_we), .ent_num(sh_num), .ent_rgb(sh_rgb), .ovf(ovf_sh)
   );

   gpal_map #(
      .SHARED(1'b0), .ENT_W(SF_EW), .PT_W(PT_W),
      .N_FINE(N_FINE), .FINE_BASE(FINE_BASE)
   ) u_sf_map (
      .ent(sf_num), .seg(sf_seg), .pt(sf_pt)
   );

   gpal_map #(
      .SHARED(1'b1), .ENT_W(SH_EW), .PT_W(PT_W),
      .N_FINE(N_FINE), .FINE_BASE(FINE_BASE)
   ) u_sh_map (
      .ent(sh_num), .seg(sh_seg), .pt(sh_pt)
   );

   // only one register write per cycle, so at most one port commits
   always_comb begin
      lut_we = sf_we | sh_we;
      if (sh_we) begin
         lut_seg   = sh_seg;
         lut_point = sh_pt;
         lut_red   = sh_rgb.r;
         lut_grn   = sh_rgb.g;
         lut_blu   = sh_rgb.b;
      end else begin
         lut_seg   = sf_seg;
         lut_point = sf_pt;
         lut_red   = sf_rgb.r;
         lut_grn   = sf_rgb.g;
         lut_blu   = sf_rgb.b;
      end
   end

endmodule

// File: rtl/gamma_pal_wport_chk.sv
module gamma_pal_wport_chk #(
   parameter int PT_W     = 9,
   parameter int N_SUPER  = 9,
   parameter int N_COARSE = 256
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr,
   input logic [1:0]      reg_addr,
   input logic            lut_we,
   input logic [1:0]      lut_seg,
   input logic [PT_W-1:0] lut_point,
   input logic            ovf_sf,
   input logic            ovf_sh
);

   // R6: a table write follows a data-register write one cycle earlier
   assert_we_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lut_we |-> $past(reg_wr && reg_addr[0]));

   // R6: strobe lasts one cycle, a data write always separates two strobes
   assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lut_we |=> !lut_we || $past(reg_wr && reg_addr[0]));

   // R2: segment code matches the pair that was written
   assert_seg_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_we && lut_seg == 2'd0) |-> $past(reg_addr == 2'd1));

   // R8: superfine points in range
   assert_super_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_we && lut_seg == 2'd0) |-> ({1'b0, lut_point} < (PT_W+1)'(N_SUPER)));

   // R9: fine points never zero, coarse points within segment, code 3 unused
   assert_fine_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_we && lut_seg == 2'd1) |-> (lut_point != '0));
   assert_coarse_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_we && lut_seg == 2'd2) |-> ({1'b0, lut_point} < (PT_W+1)'(N_COARSE)));
   assert_seg_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lut_we |-> (lut_seg != 2'd3));

   // R10: overflow flags are sticky and only rise after a data write of their pair
   assert_no_overflow_clear_sf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf_sf) |-> ovf_sf);
   assert_no_overflow_clear_sh_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf_sh) |-> ovf_sh);
   assert_overflow_cause_sf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_sf) |-> $past(reg_wr && reg_addr == 2'd1));
   assert_overflow_cause_sh_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_sh) |-> $past(reg_wr && reg_addr == 2'd3));

endmodule

bind gamma_pal_wport gamma_pal_wport_chk #(
   .PT_W(PT_W), .N_SUPER(N_SUPER), .N_COARSE(N_COARSE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .lut_we(lut_we), .lut_seg(lut_seg), .lut_point(lut_point),
   .ovf_sf(ovf_sf), .ovf_sh(ovf_sh)
);

// File: tb/sim_gamma_pal_wport.sv
`timescale 1ns/1ps
module sim_gamma_pal_wport;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic        lut_we;
   logic [1:0]  lut_seg;
   logic [8:0]  lut_point;
   logic [15:0] lut_red, lut_grn, lut_blu;
   logic        ovf_sf, ovf_sh;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gamma_pal_wport u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .lut_we(lut_we), .lut_seg(lut_seg),
      .lut_point(lut_point), .lut_red(lut_red), .lut_grn(lut_grn),
      .lut_blu(lut_blu), .ovf_sf(ovf_sf), .ovf_sh(ovf_sh)
   );

   typedef struct packed {
      logic [1:0]  seg;
      logic [8:0]  pt;
      logic [15:0] r, g, b;
   } item_t;

   item_t exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: each table write is compared against the queue head
   always @(negedge clk) begin
      if (rst_n && lut_we && !done) begin
         item_t got, want;
         got = '{lut_seg, lut_point, lut_red, lut_grn, lut_blu};
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6/R7", "unexpected table write", 64'(got), 64'd0);
         end else begin
            want = exp_q.pop_front();
            chk(got == want, "R5/R8/R9", "table write", 64'(got), 64'(want));
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   function automatic logic [31:0] lo_word(input logic [15:0] r, g, b);
      return {2'b00, r[5:0], 4'h0, g[5:0], 8'h00, b[5:0]};
   endfunction

   function automatic logic [31:0] hi_word(input logic [15:0] r, g, b);
      return {2'b00, r[15:6], g[15:6], b[15:6]};
   endfunction

   function automatic logic [31:0] idx_word(input int idx, input bit ai);
      return {16'h0, ai, 5'h0, 10'(idx)};
   endfunction

   // sends a low/high pair to a pair's data register; expects a write if asked
   task automatic send_pt(input bit shared, input int seg, input int pt,
                          input int seed, input bit expect_wr);
      logic [15:0] r, g, b;
      logic [1:0]  da;
      r  = 16'(seed * 40503 + 17);
      g  = 16'(seed * 9973 + 4099);
      b  = 16'(seed * 31337 + 999);
      da = shared ? 2'd3 : 2'd1;
      wr(da, lo_word(r, g, b));
      if (expect_wr) exp_q.push_back('{2'(seg), 9'(pt), r, g, b});
      wr(da, hi_word(r, g, b));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(lut_we == 1'b0, "R1", "lut_we in reset", 64'(lut_we), 64'd0);
      chk({ovf_sf, ovf_sh} == 2'b00, "R1", "flags in reset", 64'({ovf_sf, ovf_sh}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(lut_we == 1'b0, "R1", "lut_we after reset", 64'(lut_we), 64'd0);

      // R4: fixed index near the superfine end, repeated words, no walk-off
      wr(2'd0, idx_word(16, 1'b0));
      for (int k = 0; k < 4; k++) wr(2'd1, 32'h3FFF_FFFF);
      chk(ovf_sf == 1'b0, "R4", "fixed index stays in range", 64'(ovf_sf), 64'd0);

      // R3 R5 R8: superfine pair with auto-advance, all 9 points
      wr(2'd0, idx_word(0, 1'b1));
      for (int p = 0; p < 9; p++) send_pt(1'b0, 0, p, p + 1, 1'b1);

      // R2 R9: shared pair, fine start
      wr(2'd2, idx_word(0, 1'b1));
      for (int e = 0; e < 3; e++) send_pt(1'b1, 1, e + 1, e + 50, 1'b1);

      // R9: fine/coarse boundary entries 254, 255, 256
      wr(2'd2, idx_word(508, 1'b1));
      send_pt(1'b1, 1, 255, 70, 1'b1);
      send_pt(1'b1, 2, 0,   71, 1'b1);
      send_pt(1'b1, 2, 1,   72, 1'b1);

      // R7: a held low half is thrown away by an index write
      wr(2'd2, idx_word(4, 1'b1));
      wr(2'd3, 32'h1234_5678);
      wr(2'd2, idx_word(5, 1'b1));
      wr(2'd3, 32'h0ABC_DEF0);
      chk(exp_q.size() == 0, "R7", "queue drained, no stray write", 64'(exp_q.size()), 64'd0);
      send_pt(1'b1, 1, 4, 80, 1'b1);  // next entry still lands correctly

      // R9: last coarse entry
      wr(2'd2, idx_word(1020, 1'b1));
      send_pt(1'b1, 2, 255, 90, 1'b1);
      chk(ovf_sh == 1'b0, "R10", "no overflow at last entry", 64'(ovf_sh), 64'd0);

      // R10: shared overflow past the end
      send_pt(1'b1, 2, 0, 91, 1'b0);
      chk(ovf_sh == 1'b1, "R10", "shared overflow set", 64'(ovf_sh), 64'd1);
      chk(ovf_sf == 1'b0, "R2", "superfine flag untouched", 64'(ovf_sf), 64'd0);

      // R10: superfine overflow; index did not advance, so a new index recovers
      wr(2'd0, idx_word(18, 1'b1));
      send_pt(1'b0, 0, 0, 95, 1'b0);
      chk(ovf_sf == 1'b1, "R10", "superfine overflow set", 64'(ovf_sf), 64'd1);
      wr(2'd0, idx_word(2, 1'b1));
      send_pt(1'b0, 0, 1, 96, 1'b1);
      chk(ovf_sf == 1'b1 && ovf_sh == 1'b1, "R10", "flags sticky",
          64'({ovf_sf, ovf_sh}), 64'h3);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "all expected writes seen", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule